// File: doc/BRIEF.md
# 32-bit Operand Address Decoder

This block sits behind an instruction byte stream and turns the operand-addressing bytes of an instruction into a ready-to-use operand description. It takes one byte per handshake. The first byte is the addressing byte. It may be followed by a scale/index/base byte and then by a displacement of zero, one or four bytes. The block works out how many bytes the encoding needs and collects them. It then reports the middle field of the addressing byte and whether the operand is a register or a memory location. For a register operand it gives the register number. For a memory operand it gives the 32-bit effective address and the segment the access should use. It also reports how many bytes it took from the stream.

Register values come from the surrounding core through two combinational read ports, one for the base term and one for the index term. The address is formed in the same cycle the last byte arrives. The result is held on the outputs until the consumer acknowledges it. No new byte is taken while a result is waiting. A caller may supply a segment override together with the addressing byte.

Top module: `opnd_addr_dec`

## Requirements
- R1: The addressing byte splits into mode (bits 7:6), reg (bits 5:3) and rm (bits 2:0). `out_reg` always equals the reg field. With mode 3 the result is a register operand: `out_is_mem`=0, `out_addr`=rm zero-extended, `out_len`=1, and no further byte is taken.
- R2: With mode 0 and rm not 4 or 5, the address is the value of register rm and `out_len`=1.
- R3: With mode 0 and rm 5, no register is used. The address is a 4-byte displacement taken least significant byte first, and `out_len`=5.
- R4: Mode 1 adds one displacement byte, sign-extended to 32 bits. Mode 2 adds a 4-byte little-endian displacement. The sum wraps modulo 2^32.
- R5: With mode other than 3 and rm 4, a second byte follows with scale in bits 7:6, index in bits 5:3 and base in bits 2:0. Index 4 adds nothing. Any other index adds the value of register index shifted left by scale.
- R6: In the two-byte form with mode 0 and base 5, a 4-byte displacement replaces the base register. With mode 1 or 2, base 5 reads register 5 normally.
- R7: Segment codes are ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. When `seg_ovr_en` is high with the addressing byte, `out_seg`=`seg_ovr`. Otherwise `out_seg` is SS when a base register 4 or 5 is in use, and DS in every other case, register operands included.
- R8: `in_ready` is high while the block collects bytes and low while `out_valid` is high. Results stay stable until a cycle with `out_ack` high, after which the block is idle again.
- R9: While `rst` is high at a clock edge the block returns to idle: `in_ready`=1 and `out_valid`=0. Any partly collected instruction is discarded.
- R10: `out_len` is 1, plus 1 if the second addressing byte is present, plus 0, 1 or 4 for the displacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Stream byte present |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Block can take a byte |
| seg_ovr_en | input | 1 | Override present, sampled with the addressing byte |
| seg_ovr | input | 3 | Override segment code |
| gpr_a_sel | output | 3 | Base register number |
| gpr_a_val | input | 32 | Base register value |
| gpr_b_sel | output | 3 | Index register number |
| gpr_b_val | input | 32 | Index register value |
| out_valid | output | 1 | Result held |
| out_ack | input | 1 | Consumer takes the result |
| out_reg | output | 3 | reg field |
| out_is_mem | output | 1 | 1 = memory operand, 0 = register operand |
| out_addr | output | 32 | Effective address or register number |
| out_seg | output | 3 | Segment code |
| out_len | output | 3 | Bytes consumed |

## Verification
A state machine that has lost track of the byte count shows up as a wrong `out_len`. It also misreads the next vector's bytes, so the very next result comes out with the wrong address. A wrong byte position in displacement assembly corrupts the address on the first 4-byte vector. A misrouted register select shows as a wrong address in the cycle the result appears. The bench stalls the acknowledge for a varying number of cycles, so a result that leaks or is lost during the hold breaks the ordering of the scoreboard at once.

// File: rtl/oad_pkg.sv
package oad_pkg;
    localparam int ADDR_W    = 32;
    localparam int GPR_SEL_W = 3;
    localparam int SEG_W     = 3;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 3;

    localparam logic [SEG_W-1:0] SEG_SS = 3'd2;
    localparam logic [SEG_W-1:0] SEG_DS = 3'd3;

    localparam logic [GPR_SEL_W-1:0] SEL_STACK = 3'd4;
    localparam logic [GPR_SEL_W-1:0] SEL_FRAME = 3'd5;
    localparam logic [GPR_SEL_W-1:0] SEL_NONE  = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SIB  = 2'd1,
        ST_DISP = 2'd2,
        ST_HOLD = 2'd3
    } oad_state_e;

    typedef struct packed {
        oad_state_e             state;
        logic [1:0]             mode;
        logic [2:0]             reg_f;
        logic                   sib;
        logic [1:0]             scale;
        logic [GPR_SEL_W-1:0]   idx;
        logic [GPR_SEL_W-1:0]   base;
        logic                   ovr_en;
        logic [SEG_W-1:0]       ovr;
        logic [ADDR_W-1:0]      disp;
        logic [CNT_W-1:0]       dpos;
        logic [CNT_W-1:0]       dneed;
        logic [CNT_W-1:0]       len;
        logic                   is_mem;
        logic [ADDR_W-1:0]      addr;
        logic [SEG_W-1:0]       seg;
    } oad_regs_t;
endpackage

// File: rtl/oad_ea_sum.sv
module oad_ea_sum #(
    parameter int W = 32
) (
    input  logic         base_en,
    input  logic [W-1:0] base_val,
    input  logic         idx_en,
    input  logic [W-1:0] idx_val,
    input  logic [1:0]   scale,
    input  logic [W-1:0] disp,
    output logic [W-1:0] ea
);
    logic [W-1:0] base_term;
    logic [W-1:0] idx_term;

    always_comb begin
        base_term = base_en ? base_val : '0;
        idx_term  = idx_en ? (idx_val << scale) : '0;
        ea        = base_term + idx_term + disp;
    end

    always_comb begin
        if (!base_en && !idx_en)
            assert_disp_only_R3: assert (ea == disp);
    end
endmodule

// File: rtl/oad_seg_pick.sv
module oad_seg_pick
    import oad_pkg::*;
(
    input  logic                 ovr_en,
    input  logic [SEG_W-1:0]     ovr,
    input  logic                 is_mem,
    input  logic                 has_base,
    input  logic [GPR_SEL_W-1:0] base_sel,
    output logic [SEG_W-1:0]     seg
);
    logic stack_base;

    always_comb begin
        stack_base = is_mem && has_base &&
                     (base_sel == SEL_STACK || base_sel == SEL_FRAME);
        if (ovr_en)
            seg = ovr;
        else if (stack_base)
            seg = SEG_SS;
        else
            seg = SEG_DS;
    end

    always_comb begin
        if (ovr_en)
            assert_ovr_first_R7: assert (seg == ovr);
    end
endmodule

// File: rtl/opnd_addr_dec.sv
module opnd_addr_dec
    import oad_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [BYTE_W-1:0]    in_byte,
    output logic                 in_ready,
    input  logic                 seg_ovr_en,
    input  logic [SEG_W-1:0]     seg_ovr,
    output logic [GPR_SEL_W-1:0] gpr_a_sel,
    input  logic [ADDR_W-1:0]    gpr_a_val,
    output logic [GPR_SEL_W-1:0] gpr_b_sel,
    input  logic [ADDR_W-1:0]    gpr_b_val,
    output logic                 out_valid,
    input  logic                 out_ack,
    output logic [2:0]           out_reg,
    output logic                 out_is_mem,
    output logic [ADDR_W-1:0]    out_addr,
    output logic [SEG_W-1:0]     out_seg,
    output logic [CNT_W-1:0]     out_len
);
    localparam int PAD_W = ADDR_W - BYTE_W;

    oad_regs_t q, d;

    logic [1:0]           cur_mode;
    logic                 cur_sib;
    logic [GPR_SEL_W-1:0] cur_base;
    logic [GPR_SEL_W-1:0] cur_idx;
    logic [1:0]           cur_scale;
    logic                 cur_ovr_en;
    logic [SEG_W-1:0]     cur_ovr;
    logic                 has_base;
    logic                 use_idx;
    logic                 cur_is_mem;
    logic [ADDR_W-1:0]    disp_asm;
    logic [ADDR_W-1:0]    disp_ext;
    logic [ADDR_W-1:0]    ea;
    logic [SEG_W-1:0]     seg_w;
    logic [CNT_W-1:0]     need_now;

    function automatic logic [CNT_W-1:0] disp_bytes(input logic [1:0] m,
                                                    input logic [GPR_SEL_W-1:0] b);
        if (m == 2'd1)
            return CNT_W'(1);
        else if (m == 2'd2 || (m == 2'd0 && b == SEL_FRAME))
            return CNT_W'(4);
        else
            return '0;
    endfunction

    // operand view: fields come from the byte on the bus or from stored state
    always_comb begin
        cur_mode   = (q.state == ST_IDLE) ? in_byte[7:6] : q.mode;
        cur_sib    = (q.state == ST_SIB) || (q.state == ST_DISP && q.sib);
        cur_base   = (q.state == ST_DISP) ? q.base  : in_byte[2:0];
        cur_idx    = (q.state == ST_DISP) ? q.idx   : in_byte[5:3];
        cur_scale  = (q.state == ST_DISP) ? q.scale : in_byte[7:6];
        cur_ovr_en = (q.state == ST_IDLE) ? seg_ovr_en : q.ovr_en;
        cur_ovr    = (q.state == ST_IDLE) ? seg_ovr    : q.ovr;
        cur_is_mem = (cur_mode != 2'd3);
        has_base   = !(cur_mode == 2'd0 && cur_base == SEL_FRAME);
        use_idx    = cur_sib && (cur_idx != SEL_NONE);
        disp_asm   = q.disp | ({{PAD_W{1'b0}}, in_byte} << {q.dpos[1:0], 3'b000});
        if (q.state != ST_DISP)
            disp_ext = '0;
        else if (cur_mode == 2'd1)
            disp_ext = {{PAD_W{disp_asm[BYTE_W-1]}}, disp_asm[BYTE_W-1:0]};
        else
            disp_ext = disp_asm;
        need_now   = disp_bytes(cur_mode, cur_base);
        gpr_a_sel  = cur_base;
        gpr_b_sel  = cur_idx;
    end

    oad_ea_sum #(.W(ADDR_W)) i_sum (
        .base_en  (has_base),
        .base_val (gpr_a_val),
        .idx_en   (use_idx),
        .idx_val  (gpr_b_val),
        .scale    (cur_scale),
        .disp     (disp_ext),
        .ea       (ea)
    );

    oad_seg_pick i_seg (
        .ovr_en   (cur_ovr_en),
        .ovr      (cur_ovr),
        .is_mem   (cur_is_mem),
        .has_base (has_base),
        .base_sel (cur_base),
        .seg      (seg_w)
    );

    // next-state computation
    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (in_valid) begin
                    d.mode   = in_byte[7:6];
                    d.reg_f  = in_byte[5:3];
                    d.base   = in_byte[2:0];
                    d.idx    = SEL_NONE;
                    d.scale  = 2'd0;
                    d.sib    = 1'b0;
                    d.ovr_en = seg_ovr_en;
                    d.ovr    = seg_ovr;
                    d.disp   = '0;
                    d.dpos   = '0;
                    d.len    = CNT_W'(1);
                    if (in_byte[7:6] == 2'd3) begin
                        d.is_mem = 1'b0;
                        d.addr   = {{(ADDR_W-GPR_SEL_W){1'b0}}, in_byte[2:0]};
                        d.seg    = seg_w;
                        d.state  = ST_HOLD;
                    end else if (in_byte[2:0] == SEL_STACK) begin
                        d.state  = ST_SIB;
                    end else if (need_now == '0) begin
                        d.is_mem = 1'b1;
                        d.addr   = ea;
                        d.seg    = seg_w;
                        d.state  = ST_HOLD;
                    end else begin
                        d.dneed  = need_now;
                        d.state  = ST_DISP;
                    end
                end
            end
            ST_SIB: begin
                if (in_valid) begin
                    d.sib   = 1'b1;
                    d.scale = in_byte[7:6];
                    d.idx   = in_byte[5:3];
                    d.base  = in_byte[2:0];
                    d.len   = CNT_W'(2);
                    if (need_now == '0) begin
                        d.is_mem = 1'b1;
                        d.addr   = ea;
                        d.seg    = seg_w;
                        d.state  = ST_HOLD;
                    end else begin
                        d.dneed  = need_now;
                        d.state  = ST_DISP;
                    end
                end
            end
            ST_DISP: begin
                if (in_valid) begin
                    d.disp = disp_asm;
                    d.dpos = q.dpos + CNT_W'(1);
                    if (q.dpos + CNT_W'(1) == q.dneed) begin
                        d.len    = q.len + q.dneed;
                        d.is_mem = 1'b1;
                        d.addr   = ea;
                        d.seg    = seg_w;
                        d.state  = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (out_ack)
                    d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            q.state  <= ST_IDLE;
            q.idx    <= SEL_NONE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        in_ready   = (q.state != ST_HOLD);
        out_valid  = (q.state == ST_HOLD);
        out_reg    = q.reg_f;
        out_is_mem = q.is_mem;
        out_addr   = q.addr;
        out_seg    = q.seg;
        out_len    = q.len;
    end

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ack |=> out_valid && $stable(out_addr) &&
                                  $stable(out_len) && $stable(out_seg));

    assert_reg_operand_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_is_mem |-> out_len == 3'd1 &&
                                     out_addr[ADDR_W-1:GPR_SEL_W] == '0);

    assert_len_legal_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_len == 3'd1 || out_len == 3'd2 || out_len == 3'd3 ||
                       out_len == 3'd5 || out_len == 3'd6));

    assert_result_after_byte_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    assert_ack_frees_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ack |=> in_ready && !out_valid);
endmodule

// File: tb/test_opnd_addr_dec.sv
module test_opnd_addr_dec;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_ready;
    logic        seg_ovr_en = 1'b0;
    logic [2:0]  seg_ovr = '0;
    logic [2:0]  gpr_a_sel, gpr_b_sel;
    logic [31:0] gpr_a_val, gpr_b_val;
    logic        out_valid;
    logic        out_ack = 1'b0;
    logic [2:0]  out_reg;
    logic        out_is_mem;
    logic [31:0] out_addr;
    logic [2:0]  out_seg;
    logic [2:0]  out_len;

    int n_checks = 0;
    int n_fail   = 0;
    int n_seen   = 0;

    typedef struct {
        logic        is_mem;
        logic [31:0] addr;
        logic [2:0]  rg;
        logic [2:0]  seg;
        logic [2:0]  len;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] gpr_val(input logic [2:0] i);
        case (i)
            3'd0: return 32'h1000_0000;
            3'd1: return 32'h0000_0010;
            3'd2: return 32'hFFFF_FFF0;
            3'd3: return 32'h1234_5678;
            3'd4: return 32'h0000_8000;
            3'd5: return 32'h0002_0000;
            3'd6: return 32'h8000_0001;
            default: return 32'h7FFF_FFFF;
        endcase
    endfunction

    assign gpr_a_val = gpr_val(gpr_a_sel);
    assign gpr_b_val = gpr_val(gpr_b_sel);

    opnd_addr_dec i_opnd_addr_dec (
        .clk, .rst, .in_valid, .in_byte, .in_ready, .seg_ovr_en, .seg_ovr,
        .gpr_a_sel, .gpr_a_val, .gpr_b_sel, .gpr_b_val, .out_valid, .out_ack,
        .out_reg, .out_is_mem, .out_addr, .out_seg, .out_len
    );

    task automatic check(input bit ok, input string tag, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    function automatic exp_t model(input logic [47:0] pk, input logic oe,
                                   input logic [2:0] os, input string tag);
        exp_t e;
        logic [7:0]  m = pk[7:0];
        logic [2:0]  b, ix;
        logic [1:0]  sc;
        logic        sibf, nob;
        int          p, dl;
        logic [31:0] disp, a;
        e.tag = tag;
        e.rg  = m[5:3];
        if (m[7:6] == 2'd3) begin
            e.is_mem = 1'b0;
            e.addr   = {29'd0, m[2:0]};
            e.seg    = oe ? os : 3'd3;
            e.len    = 3'd1;
            return e;
        end
        p = 1; sibf = 1'b0; b = m[2:0]; ix = 3'd4; sc = 2'd0;
        if (m[2:0] == 3'd4) begin
            sibf = 1'b1; p = 2;
            b = pk[10:8]; ix = pk[13:11]; sc = pk[15:14];
        end
        nob = (m[7:6] == 2'd0 && b == 3'd5);
        dl  = (m[7:6] == 2'd1) ? 1 : ((m[7:6] == 2'd2 || nob) ? 4 : 0);
        disp = '0;
        for (int k = 0; k < dl; k++)
            disp = disp | ({24'd0, pk[8*(p+k) +: 8]} << (8*k));
        if (dl == 1)
            disp = {{24{disp[7]}}, disp[7:0]};
        a = (nob ? 32'd0 : gpr_val(b)) + disp;
        if (sibf && ix != 3'd4)
            a = a + (gpr_val(ix) << sc);
        e.is_mem = 1'b1;
        e.addr   = a;
        e.seg    = oe ? os : ((!nob && (b == 3'd4 || b == 3'd5)) ? 3'd2 : 3'd3);
        e.len    = 3'(p + dl);
        return e;
    endfunction

    // driver; entered and left at a falling edge
    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_vec(input logic [47:0] pk, input int n, input logic oe,
                           input logic [2:0] os, input string tag);
        exp_t e = model(pk, oe, os, tag);
        if (int'(e.len) != n)
            $display("bench vector %s length mismatch", tag);
        exp_q.push_back(e);
        seg_ovr_en = oe;
        seg_ovr    = os;
        for (int i = 0; i < n; i++) begin
            send_byte(pk[8*i +: 8]);
            seg_ovr_en = 1'b0;
            seg_ovr    = '0;
        end
        in_valid = 1'b0;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            out_ack = 1'b0;
            if (out_valid && !rst) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "result with empty scoreboard");
                end else begin
                    e = exp_q.pop_front();
                    check(out_is_mem == e.is_mem && out_addr == e.addr &&
                          out_reg == e.rg && out_seg == e.seg && out_len == e.len,
                          e.tag,
                          $sformatf("mem=%0b addr=%h reg=%0d seg=%0d len=%0d exp mem=%0b addr=%h reg=%0d seg=%0d len=%0d",
                                    out_is_mem, out_addr, out_reg, out_seg, out_len,
                                    e.is_mem, e.addr, e.rg, e.seg, e.len));
                end
                for (int s = 0; s < (n_seen % 3); s++) begin
                    @(negedge clk);
                    check(out_valid && !in_ready && out_addr == e.addr && out_len == e.len,
                          "R8", $sformatf("hold valid=%0b ready=%0b addr=%h exp 1 0 %h",
                                          out_valid, in_ready, out_addr, e.addr));
                end
                n_seen++;
                out_ack = 1'b1;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(in_ready == 1'b1 && out_valid == 1'b0, "R9",
              $sformatf("after reset ready=%0b valid=%0b exp 1 0", in_ready, out_valid));

        run_vec(48'hD3, 1, 1'b0, 3'd0, "R1 register operand");
        run_vec(48'h09, 1, 1'b0, 3'd0, "R2 register indirect");
        run_vec(48'h12345678_05, 5, 1'b0, 3'd0, "R3 absolute disp32");
        run_vec(48'h80_42, 2, 1'b0, 3'd0, "R4 negative disp8");
        run_vec(48'h04_45, 2, 1'b0, 3'd0, "R7 frame base stack segment");
        run_vec(48'h01000000_87, 5, 1'b0, 3'd0, "R4 disp32");
        run_vec(48'h80000000_86, 5, 1'b0, 3'd0, "R4 wrap modulo");
        run_vec(48'h88_04, 2, 1'b0, 3'd0, "R5 scaled index");
        run_vec(48'h23_04, 2, 1'b0, 3'd0, "R5 no index");
        run_vec(48'h00001000_DD_04, 6, 1'b0, 3'd0, "R6 no base disp32");
        run_vec(48'hFC_45_44, 3, 1'b0, 3'd0, "R6 frame base in pair form");
        run_vec(48'h00000010_24_84, 6, 1'b0, 3'd0, "R10 stack base len 6");
        run_vec(48'h00_45, 2, 1'b1, 3'd4, "R7 override wins");
        run_vec(48'h68_04, 2, 1'b0, 3'd0, "R7 index 5 keeps data segment");
        run_vec(48'hE9, 1, 1'b1, 3'd5, "R1 register operand with override");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);

        // reset in the middle of a displacement
        send_byte(8'h05);
        send_byte(8'hAA);
        send_byte(8'hBB);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(in_ready == 1'b1 && out_valid == 1'b0, "R9",
              $sformatf("mid-stream reset ready=%0b valid=%0b exp 1 0", in_ready, out_valid));
        run_vec(48'h0A, 1, 1'b0, 3'd0, "R9 fresh decode after reset");
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule